// File: doc/BRIEF.md
# 16-bit Register-Pair Arithmetic Unit

This unit performs the wide arithmetic of a small processor's register pairs: addition of a source pair into HL, IX or IY, addition and subtraction with the stored carry into HL, and increment or decrement of any pair. The register file stays outside the unit. The unit receives the current pair values and the flag byte, and it captures them at the cycle that accepts a command. It works through the operation's fixed cycle budget and then presents the 16-bit result and the updated flag byte together with a one-cycle done pulse. The surrounding core writes the result back.

A command is made of an operation code, a destination select and a 2-bit pair code. Pair code 2 is context dependent. It names the destination register itself, so adding pair 2 into IX doubles IX. In the carry forms the destination is always HL.

Top module: `pair_alu16`

## Requirements
- R1: After reset, result_o and flags_o are zero and done_o and busy_o are low.
- R2: Pair code 0 selects BC, 1 selects DE and 3 selects SP. Code 2 selects the destination register (dst_i 0 = HL, 1 = IX, 2 = IY). Operation codes are 0 ADD, 1 ADC, 2 SBC, 3 INC and 4 DEC. Codes 5 to 7 and dst_i 3 are reserved.
- R3: ADD gives destination + source modulo 2^16. The flag byte has S at bit 7, Z at bit 6, H at bit 4, P/V at bit 2, N at bit 1 and C at bit 0. ADD sets H to the carry out of bit 11 and C to the carry out of bit 15, and clears N. Bits 7, 6, 5, 3 and 2 keep their incoming values.
- R4: ADC gives HL + source + C_in. It sets S to result bit 15, Z when the result is zero, H to the carry out of bit 11, P/V to signed overflow and C to the carry out of bit 15, and clears N. dst_i is ignored, so pair code 2 means HL.
- R5: SBC gives HL - source - C_in. It sets S and Z from the result, H to the borrow from bit 12 into bit 11, P/V to signed overflow and C to the overall borrow, and sets N. dst_i is ignored.
- R6: INC and DEC add or subtract 1 modulo 2^16 on the selected pair, and flags_o equals the captured flags_i unchanged.
- R7: done_o pulses high for exactly one cycle. It rises at the Nth rising edge after the edge that accepts start_i. N is 11 for ADD into HL, 15 for ADD into IX or IY, 15 for ADC and SBC, 10 for INC or DEC of IX or IY, and 6 for INC or DEC of any other pair.
- R8: busy_o is high from the accepting edge up to the done edge. A start_i seen while busy_o is high is ignored. Register values are captured at acceptance, so later input changes have no effect.
- R9: result_o and flags_o change only at the edge where done_o rises, and they hold until the next operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command strobe |
| op_i | input | 3 | Operation code |
| dst_i | input | 2 | Destination select |
| pair_i | input | 2 | Source pair code |
| bc_i | input | 16 | BC pair value |
| de_i | input | 16 | DE pair value |
| hl_i | input | 16 | HL pair value |
| sp_i | input | 16 | SP value |
| ix_i | input | 16 | IX value |
| iy_i | input | 16 | IY value |
| flags_i | input | 8 | Current flag byte |
| result_o | output | 16 | Completed result |
| flags_o | output | 8 | Updated flag byte |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Operation in progress |

## Verification
The assertions assume that every accepted command carries a defined operation code (0 to 4) and destination (0 to 2). An assertion flags any reserved code at a start strobe. The stimulus issues only legal commands. It holds the command inputs steady from the falling edge before a strobe through the edge that samples it. Register values and strobes that arrive while the unit is busy are deliberately varied, and the assertions expect the unit to discard them.

// File: rtl/pair_alu16_pkg.sv
package pair_alu16_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SBC = 3'd2,
    OP_INC = 3'd3,
    OP_DEC = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    DST_HL = 2'd0,
    DST_IX = 2'd1,
    DST_IY = 2'd2
  } dst_e;

  localparam int FS = 7;
  localparam int FZ = 6;
  localparam int FH = 4;
  localparam int FV = 2;
  localparam int FN = 1;
  localparam int FC = 0;
endpackage

// File: rtl/pair_src_sel.sv
module pair_src_sel
  import pair_alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  op_e          op_i,
  input  dst_e         dst_i,
  input  logic [1:0]   pair_i,
  input  logic [W-1:0] bc_i,
  input  logic [W-1:0] de_i,
  input  logic [W-1:0] hl_i,
  input  logic [W-1:0] sp_i,
  input  logic [W-1:0] ix_i,
  input  logic [W-1:0] iy_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o,
  output logic         idx_tgt_o,
  output logic         step_o
);
  logic         use_dst, idx;
  logic [W-1:0] dreg, src;

  always_comb begin
    step_o  = (op_i == OP_INC) || (op_i == OP_DEC);
    // carry forms always target HL
    use_dst = (op_i == OP_ADD) || step_o;
    idx     = use_dst && (dst_i != DST_HL);
    dreg    = !idx ? hl_i : ((dst_i == DST_IX) ? ix_i : iy_i);
    case (pair_i)
      2'd0:    src = bc_i;
      2'd1:    src = de_i;
      2'd2:    src = dreg;
      default: src = sp_i;
    endcase
    a_o       = step_o ? src : dreg;
    b_o       = src;
    idx_tgt_o = step_o ? (idx && pair_i == 2'd2) : idx;
  end
endmodule

// File: rtl/pair_arith.sv
module pair_arith
  import pair_alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  op_e          op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [7:0]   flags_i,
  output logic [W-1:0] res_o,
  output logic [7:0]   flags_o
);
  localparam int HB = W - 4;

  logic         cin;
  logic [W:0]   full;
  logic [HB:0]  low;

  always_comb begin
    cin     = ((op_i == OP_ADC) || (op_i == OP_SBC)) && flags_i[FC];
    full    = '0;
    low     = '0;
    res_o   = a_i;
    flags_o = flags_i;
    case (op_i)
      OP_ADD, OP_ADC: begin
        full = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin};
        low  = {1'b0, a_i[HB-1:0]} + {1'b0, b_i[HB-1:0]} + {{HB{1'b0}}, cin};
        res_o = full[W-1:0];
        flags_o[FH] = low[HB];
        flags_o[FC] = full[W];
        flags_o[FN] = 1'b0;
        if (op_i == OP_ADC) begin
          flags_o[FS] = res_o[W-1];
          flags_o[FZ] = (res_o == '0);
          flags_o[FV] = (a_i[W-1] == b_i[W-1]) && (res_o[W-1] != a_i[W-1]);
        end
      end
      OP_SBC: begin
        full = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, cin};
        low  = {1'b0, a_i[HB-1:0]} - {1'b0, b_i[HB-1:0]} - {{HB{1'b0}}, cin};
        res_o = full[W-1:0];
        flags_o[FS] = res_o[W-1];
        flags_o[FZ] = (res_o == '0);
        flags_o[FH] = low[HB];
        flags_o[FV] = (a_i[W-1] != b_i[W-1]) && (res_o[W-1] != a_i[W-1]);
        flags_o[FN] = 1'b1;
        flags_o[FC] = full[W];
      end
      OP_DEC:  res_o = a_i - {{(W-1){1'b0}}, 1'b1};
      default: res_o = a_i + {{(W-1){1'b0}}, 1'b1};
    endcase
  end
endmodule

// File: rtl/pair_seq.sv
module pair_seq #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] lat_i,
  output logic             accept_o,
  output logic             last_o,
  output logic             busy_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q;

  assign accept_o = start_i && !busy_q;
  assign last_o   = busy_q && (cnt_q == CNT_W'(1));
  assign busy_o   = busy_q;
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept_o) begin
        cnt_q  <= lat_i;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (last_o) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
    end
  end

  p_accept_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> busy_q);
  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  p_done_after_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> ($past(busy_q) && !busy_q));
  p_cnt_live_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q != '0));
endmodule

// File: rtl/pair_alu16.sv
module pair_alu16
  import pair_alu16_pkg::*;
#(
  parameter int W            = 16,
  parameter int LAT_ADD      = 11,
  parameter int LAT_ADD_IDX  = 15,
  parameter int LAT_CARRY    = 15,
  parameter int LAT_STEP     = 6,
  parameter int LAT_STEP_IDX = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [2:0]   op_i,
  input  logic [1:0]   dst_i,
  input  logic [1:0]   pair_i,
  input  logic [W-1:0] bc_i,
  input  logic [W-1:0] de_i,
  input  logic [W-1:0] hl_i,
  input  logic [W-1:0] sp_i,
  input  logic [W-1:0] ix_i,
  input  logic [W-1:0] iy_i,
  input  logic [7:0]   flags_i,
  output logic [W-1:0] result_o,
  output logic [7:0]   flags_o,
  output logic         done_o,
  output logic         busy_o
);
  localparam int M1      = (LAT_ADD > LAT_ADD_IDX) ? LAT_ADD : LAT_ADD_IDX;
  localparam int M2      = (LAT_CARRY > LAT_STEP) ? LAT_CARRY : LAT_STEP;
  localparam int M3      = (M1 > M2) ? M1 : M2;
  localparam int MAX_LAT = (M3 > LAT_STEP_IDX) ? M3 : LAT_STEP_IDX;
  localparam int CNT_W   = $clog2(MAX_LAT + 1);

  op_e              op;
  dst_e             dst;
  logic [W-1:0]     a_v, b_v, res_c;
  logic [7:0]       flg_c;
  logic             idx_tgt, step, accept, last;
  logic [CNT_W-1:0] lat_c;
  logic [W-1:0]     pend_res, res_q;
  logic [7:0]       pend_flg, flg_q;

  assign op  = op_e'(op_i);
  assign dst = dst_e'(dst_i);

  pair_src_sel #(.W(W)) u_sel (
    .op_i(op), .dst_i(dst), .pair_i(pair_i),
    .bc_i(bc_i), .de_i(de_i), .hl_i(hl_i), .sp_i(sp_i), .ix_i(ix_i), .iy_i(iy_i),
    .a_o(a_v), .b_o(b_v), .idx_tgt_o(idx_tgt), .step_o(step)
  );

  pair_arith #(.W(W)) u_arith (
    .op_i(op), .a_i(a_v), .b_i(b_v), .flags_i(flags_i),
    .res_o(res_c), .flags_o(flg_c)
  );

  always_comb begin
    if (step)               lat_c = idx_tgt ? CNT_W'(LAT_STEP_IDX) : CNT_W'(LAT_STEP);
    else if (op == OP_ADD)  lat_c = idx_tgt ? CNT_W'(LAT_ADD_IDX) : CNT_W'(LAT_ADD);
    else                    lat_c = CNT_W'(LAT_CARRY);
  end

  pair_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .lat_i(lat_c),
    .accept_o(accept), .last_o(last), .busy_o(busy_o), .done_o(done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_res <= '0;
      pend_flg <= '0;
      res_q    <= '0;
      flg_q    <= '0;
    end else begin
      if (accept) begin
        pend_res <= res_c;
        pend_flg <= flg_c;
      end
      if (last) begin
        res_q <= pend_res;
        flg_q <= pend_flg;
      end
    end
  end

  assign result_o = res_q;
  assign flags_o  = flg_q;

  p_legal_cmd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (op_i <= 3'd4 && dst_i != 2'd3));
  p_step_flags_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && step) |=> (pend_flg == $past(flags_i)));
  p_add_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && op == OP_ADD) |=>
      ({pend_flg[7:5], pend_flg[3:2]} == {$past(flags_i[7:5]), $past(flags_i[3:2])}));
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(result_o) && $stable(flags_o)));
endmodule

// File: tb/tb_pair_alu16.sv
module tb_pair_alu16;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [1:0]  dst = '0, pair = '0;
  logic [15:0] bc = '0, de = '0, hl = '0, sp = '0, ix = '0, iy = '0;
  logic [7:0]  fin = '0;
  logic [15:0] result;
  logic [7:0]  flags;
  logic        done, busy;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R3";

  // reference model state
  bit          m_busy = 0, m_done = 0;
  int          m_left = 0;
  logic [15:0] m_res = '0, p_res = '0;
  logic [7:0]  m_flg = '0, p_flg = '0;
  string       m_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  pair_alu16 dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .dst_i(dst), .pair_i(pair),
    .bc_i(bc), .de_i(de), .hl_i(hl), .sp_i(sp), .ix_i(ix), .iy_i(iy), .flags_i(fin),
    .result_o(result), .flags_o(flags), .done_o(done), .busy_o(busy)
  );

  function automatic int sgn(int v);
    return (v >= 32768) ? v - 65536 : v;
  endfunction

  task automatic ref_op(output logic [15:0] res, output logic [7:0] f, output int lat);
    int d, s, cf, t, h, v;
    bit idx, step;
    step = (op == 3) || (op == 4);
    idx  = (op == 0 || step) && dst != 0;
    d    = !idx ? int'(hl) : (dst == 1 ? int'(ix) : int'(iy));
    s    = pair == 0 ? int'(bc) : pair == 1 ? int'(de) : pair == 2 ? d : int'(sp);
    cf   = int'(fin[0]);
    f    = fin;
    case (op)
      0: begin
        t = d + s; res = t[15:0];
        f[4] = ((d % 4096) + (s % 4096)) > 4095; f[1] = 0; f[0] = t > 65535;
        lat = idx ? 15 : 11;
      end
      1: begin
        t = d + s + cf; res = t[15:0];
        h = (d % 4096) + (s % 4096) + cf; v = sgn(d) + sgn(s) + cf;
        f[7] = res[15]; f[6] = res == 0; f[4] = h > 4095;
        f[2] = (v > 32767) || (v < -32768); f[1] = 0; f[0] = t > 65535;
        lat = 15;
      end
      2: begin
        t = d - s - cf; res = t[15:0];
        h = (d % 4096) - (s % 4096) - cf; v = sgn(d) - sgn(s) - cf;
        f[7] = res[15]; f[6] = res == 0; f[4] = h < 0;
        f[2] = (v > 32767) || (v < -32768); f[1] = 1; f[0] = t < 0;
        lat = 15;
      end
      default: begin
        t = (op == 3) ? s + 1 : s + 65535; res = t[15:0];
        lat = (pair == 2 && dst != 0) ? 10 : 6;
      end
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_left = 0; m_res = '0; m_flg = '0;
    end else begin
      int lat;
      m_done = 0;
      if (m_busy) begin
        m_left--;
        if (m_left == 0) begin
          m_busy = 0; m_done = 1; m_res = p_res; m_flg = p_flg;
        end
      end else if (start) begin
        ref_op(p_res, p_flg, lat);
        m_left = lat; m_busy = 1; m_tag = cur_tag;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R7", int'(done), int'(m_done), "done");
      chk("R8", int'(busy), int'(m_busy), "busy");
      chk(m_done ? m_tag : "R9", int'(result), int'(m_res), "result");
      chk(m_done ? m_tag : "R9", int'(flags), int'(m_flg), "flags");
    end
  end

  task automatic issue(input int o, input int d, input int p, input string tag);
    @(negedge clk);
    op = 3'(o); dst = 2'(d); pair = 2'(p); cur_tag = tag; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_op();
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run(input int o, input int d, input int p, input string tag);
    issue(o, d, p, tag);
    finish_op();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", int'(result), 0, "reset result");
    chk("R1", int'(flags), 0, "reset flags");
    chk("R1", int'({done, busy}), 0, "reset done/busy");

    bc = 16'h0001; de = 16'h0000; hl = 16'h0FFF; sp = 16'hFFFF;
    ix = 16'h8001; iy = 16'h1234; fin = 8'hFF;
    run(0, 0, 0, "R3");          // ADD HL,BC half carry, S/Z/PV kept
    hl = 16'h8000;
    run(0, 0, 2, "R2");          // ADD HL,HL -> 0, carry
    run(0, 1, 2, "R2");          // ADD IX,IX
    de = 16'h0F0F; fin = 8'h00;
    run(0, 2, 1, "R3");          // ADD IY,DE
    run(0, 1, 3, "R3");          // ADD IX,SP
    hl = 16'h7FFF; de = 16'h0000; fin = 8'h01;
    run(1, 0, 1, "R4");          // ADC 7FFF+0+1 overflow
    hl = 16'hFFFF; sp = 16'h0000;
    run(1, 0, 3, "R4");          // ADC to zero with carry
    hl = 16'h4000; fin = 8'h00;
    run(1, 1, 2, "R4");          // dst ignored, pair 2 = HL
    hl = 16'h1000; bc = 16'h0001;
    run(2, 0, 0, "R5");          // SBC half borrow
    hl = 16'h8000; fin = 8'h01; bc = 16'h0000;
    run(2, 0, 0, "R5");          // SBC overflow
    run(2, 2, 2, "R5");          // SBC HL,HL with carry -> FFFF borrow
    hl = 16'h0005; bc = 16'h0005; fin = 8'h00;
    run(2, 0, 0, "R5");          // SBC to zero
    sp = 16'hFFFF; fin = 8'hA5;
    run(3, 0, 3, "R6");          // INC SP wraps
    bc = 16'h0000;
    run(4, 0, 0, "R6");          // DEC BC wraps
    ix = 16'h00FF;
    run(3, 1, 2, "R6");          // INC IX
    iy = 16'h0100;
    run(4, 2, 2, "R6");          // DEC IY
    run(3, 0, 2, "R6");          // INC HL
    // R8: strobe and input changes while busy are ignored
    hl = 16'h2222; bc = 16'h1111; fin = 8'h00;
    issue(0, 0, 0, "R8");
    @(negedge clk);
    hl = 16'h9999; op = 3'd3; pair = 2'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    finish_op();
    repeat (3) @(negedge clk);   // R9 hold after done
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule